// File: doc/BRIEF.md
# Suspend Wake-Up Release Sequencer

This block brings a device out of a low-power suspend state in a controlled order. While suspended, every user output is held in its suspend behaviour (tri-state unless a pin has been given another one), and all clocked storage is write-protected. When the wake indication goes high, the block times two release points on the wake-up timing clock. At the first point, the output hold is dropped. At the second point, storage writes are re-enabled.

Each release point has its own 11-bit delay setting. Outputs must always come back before storage becomes writable. A setting that would break this order is flagged and repaired. When the set/reset enable is on, a one-cycle global set/reset pulse comes just before writes are re-enabled, so storage starts from its initial values. When it is off, the contents kept through suspend stay as they are. If the wake indication drops partway through, the sequence is abandoned and the suspend protections come back at once.

Top module: `wake_release_seq`

## Requirements
- R1: After reset, with wake low, hold_o is 1 and we_o, gsr_o, err_o and done_o are all 0.
- R2: Both delay settings and gsr_en_i are captured on the clock edge where wake_i is first seen high (wake_i high, and low on the previous edge). Changes to them after that edge have no effect on the running sequence.
- R3: A captured delay of 0 is treated as 1. A captured delay above 1024 is treated as 1024.
- R4: Call the capture edge edge 0, and let Do be the clamped output delay. hold_o goes low after edge Do and stays low while wake_i stays high.
- R5: Let Dw be the effective write-protect delay: the clamped write-protect delay, or Do+1 under R6. we_o and done_o go high after edge Dw and stay high while wake_i stays high.
- R6: If the clamped output delay is greater than or equal to the clamped write-protect delay, err_o goes high after edge 0 and Dw becomes Do+1. Otherwise err_o is low after edge 0. err_o holds its value until the next capture edge.
- R7: With gsr_en_i captured as 1, gsr_o is high for exactly the one cycle between edge Dw-1 and edge Dw. With gsr_en_i captured as 0, gsr_o never goes high.
- R8: While wake_i is low, hold_o is 1 and we_o, gsr_o and done_o are 0, with no clock edge needed. A sequence cut short by wake_i going low restarts from edge 0 on the next capture edge.
- R9: we_o is never high while hold_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wake-up timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Wake indication, synchronous to clk |
| out_dly_i | input | 11 | Output release delay in cycles |
| wp_dly_i | input | 11 | Write-protect release delay in cycles |
| gsr_en_i | input | 1 | Issue a set/reset pulse before write enable |
| hold_o | output | 1 | 1 = outputs kept in suspend behaviour |
| we_o | output | 1 | 1 = clocked storage may be written |
| gsr_o | output | 1 | One-cycle global set/reset pulse |
| err_o | output | 1 | Delay settings broke the release order |
| done_o | output | 1 | Release sequence complete |

## Verification
The hardest condition to reach is an abort in the middle of a sequence that is immediately followed by a new wake. In that situation, stale count state could leak into the restarted run. The stimulus drops wake_i between the two release points of a long sequence and checks the outputs in the same half cycle. It then raises wake again one cycle later with different settings. The far ends of the clamp range also take deliberate stimulus: a sequence at the 1024-cycle ceiling, and the settings 0 and 2047, which must land on 1 and 1024.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int unsigned DLY_W_DEF = 11;
  localparam int unsigned DLY_MAX_DEF = 1024;

  // Bring a raw delay setting into 1..hi.
  function automatic int unsigned clamp_dly(int unsigned v, int unsigned hi);
    if (v == 0) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

  // Write-protect release point that keeps outputs strictly first.
  function automatic int unsigned wp_effective(int unsigned o, int unsigned w);
    return (o >= w) ? o + 1 : w;
  endfunction

  function automatic logic order_broken(int unsigned o, int unsigned w);
    return o >= w;
  endfunction
endpackage

// File: rtl/wrs_edge.sv
module wrs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  output logic rise_o,
  output logic abort_o
);
  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_i;
  end

  assign rise_o  = wake_i & ~wake_q;
  assign abort_o = ~wake_i;
endmodule

// File: rtl/wrs_cfg.sv
module wrs_cfg #(
  parameter int unsigned DLY_W   = wrs_pkg::DLY_W_DEF,
  parameter int unsigned DLY_MAX = wrs_pkg::DLY_MAX_DEF,
  parameter int unsigned CNT_W   = $clog2(DLY_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [DLY_W-1:0] out_dly_i,
  input  logic [DLY_W-1:0] wp_dly_i,
  input  logic             gsr_en_i,
  output logic [CNT_W-1:0] out_n_o,
  output logic [CNT_W-1:0] wp_n_o,
  output logic [CNT_W-1:0] gsr_at_o,
  output logic             gsr_en_o,
  output logic             err_o
);
  int unsigned o_c, w_c, w_e;

  always_comb begin
    o_c = wrs_pkg::clamp_dly(32'(out_dly_i), DLY_MAX);
    w_c = wrs_pkg::clamp_dly(32'(wp_dly_i), DLY_MAX);
    w_e = wrs_pkg::wp_effective(o_c, w_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_n_o  <= CNT_W'(1);
      wp_n_o   <= CNT_W'(2);
      gsr_at_o <= CNT_W'(1);
      gsr_en_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (capture_i) begin
      out_n_o  <= CNT_W'(o_c);
      wp_n_o   <= CNT_W'(w_e);
      gsr_at_o <= CNT_W'(w_e - 1);
      gsr_en_o <= gsr_en_i;
      err_o    <= wrs_pkg::order_broken(o_c, w_c);
    end
  end

  // R3: captured release points stay inside the legal range
  a_r3_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    out_n_o != '0 && out_n_o <= CNT_W'(DLY_MAX) && wp_n_o <= CNT_W'(DLY_MAX + 1));
  // R6: write-protect release always lies after output release
  a_r6_wp_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    wp_n_o > out_n_o);
endmodule

// File: rtl/wrs_count.sv
module wrs_count #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (abort_i) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (start_i) begin
      cnt_o <= CNT_W'(1);
      run_o <= 1'b1;
    end else if (run_o) begin
      if (cnt_o == limit_i) run_o <= 1'b0;
      else                  cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R4: the elapsed count never passes the last release point
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (cnt_o != '0 && cnt_o <= limit_i));
endmodule

// File: rtl/wake_release_seq.sv
module wake_release_seq #(
  parameter int unsigned DLY_W   = wrs_pkg::DLY_W_DEF,
  parameter int unsigned DLY_MAX = wrs_pkg::DLY_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_i,
  input  logic [DLY_W-1:0] out_dly_i,
  input  logic [DLY_W-1:0] wp_dly_i,
  input  logic             gsr_en_i,
  output logic             hold_o,
  output logic             we_o,
  output logic             gsr_o,
  output logic             err_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(DLY_MAX + 2);

  logic             rise, abort;
  logic [CNT_W-1:0] out_n, wp_n, gsr_at, cnt;
  logic             gsr_en_q, err_q, running;
  logic             hit_out, hit_wp, hit_gsr;
  logic             hold_r, we_r, gsr_r, done_r;

  wrs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .rise_o(rise), .abort_o(abort)
  );

  wrs_cfg #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture_i(rise),
    .out_dly_i(out_dly_i), .wp_dly_i(wp_dly_i), .gsr_en_i(gsr_en_i),
    .out_n_o(out_n), .wp_n_o(wp_n), .gsr_at_o(gsr_at),
    .gsr_en_o(gsr_en_q), .err_o(err_q)
  );

  wrs_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .start_i(rise), .abort_i(abort),
    .limit_i(wp_n), .cnt_o(cnt), .run_o(running)
  );

  // Release events taken from the shared elapsed count
  assign hit_out = running && (cnt == out_n);
  assign hit_wp  = running && (cnt == wp_n);
  assign hit_gsr = running && (cnt == gsr_at) && gsr_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r <= 1'b1;
      we_r   <= 1'b0;
      gsr_r  <= 1'b0;
      done_r <= 1'b0;
    end else if (abort || rise) begin
      hold_r <= 1'b1;
      we_r   <= 1'b0;
      gsr_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      if (hit_out) hold_r <= 1'b0;
      if (hit_wp) begin
        we_r   <= 1'b1;
        done_r <= 1'b1;
      end
      gsr_r <= hit_gsr;
    end
  end

  // A low wake restores suspend protection without waiting for a clock edge
  assign hold_o = hold_r | ~wake_i;
  assign we_o   = we_r & wake_i;
  assign gsr_o  = gsr_r & wake_i;
  assign done_o = done_r & wake_i;
  assign err_o  = err_q;

  // R9: storage never writable while outputs are still held
  a_r9_order: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> !hold_o);
  // R7: set/reset pulse is one cycle and write enable follows it
  a_r7_gsr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (gsr_r && wake_i) |=> (we_r && !gsr_r));
  // R6: a repaired order puts write enable one cycle after output release
  a_r6_forced_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_r) && err_q) |-> (!$past(hold_r) && $past(hold_r, 2)));
  // R8: a low wake clears every registered release
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_i |=> (hold_r && !we_r && !gsr_r && !done_r));
endmodule

// File: tb/sim_wake_release_seq.sv
module sim_wake_release_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_i = 1'b0;
  logic [10:0] out_dly_i = 11'd4;
  logic [10:0] wp_dly_i = 11'd5;
  logic        gsr_en_i = 1'b0;
  logic        hold_o, we_o, gsr_o, err_o, done_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  wake_release_seq u0 (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .out_dly_i(out_dly_i),
    .wp_dly_i(wp_dly_i), .gsr_en_i(gsr_en_i), .hold_o(hold_o), .we_o(we_o),
    .gsr_o(gsr_o), .err_o(err_o), .done_o(done_o)
  );

  // Reference model: absolute cycle numbers of the release events
  int unsigned cyc, t0, no, nw;
  bit m_prev, m_act, m_gen, m_hold, m_we, m_gsr, m_done, m_err;

  function automatic int unsigned lim(int unsigned v);
    if (v < 1) return 1;
    return (v > 1024) ? 1024 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_prev = 0; m_act = 0; m_gen = 0;
      m_hold = 1; m_we = 0; m_gsr = 0; m_done = 0; m_err = 0;
    end else begin
      if (!wake_i) begin
        m_act = 0; m_hold = 1; m_we = 0; m_gsr = 0; m_done = 0;
      end else if (!m_prev) begin
        m_act = 1; t0 = cyc; m_gen = gsr_en_i;
        no = lim(out_dly_i); nw = lim(wp_dly_i);
        m_err = (no >= nw);
        if (m_err) nw = no + 1;
        m_hold = 1; m_we = 0; m_gsr = 0; m_done = 0;
      end else if (m_act) begin
        m_hold = !((cyc - t0) >= no);
        m_we   = (cyc - t0) >= nw;
        m_done = m_we;
        m_gsr  = m_gen && ((cyc - t0) == nw - 1);
      end
      m_prev = wake_i;
      cyc++;
    end
  end

  task automatic chk(bit got, bit exp, string req, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s at cycle %0d: actual %0b expected %0b",
               req, cur_req, what, cyc, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(hold_o, m_hold | ~wake_i, "R4", "hold_o");
    chk(we_o,   m_we & wake_i,    "R5", "we_o");
    chk(done_o, m_done & wake_i,  "R5", "done_o");
    chk(gsr_o,  m_gsr & wake_i,   "R7", "gsr_o");
    chk(err_o,  m_err,            "R6", "err_o");
    chk(!(we_o && hold_o), 1'b1,  "R9", "order");
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic drive(bit w, int unsigned od, int unsigned wd, bit ge);
    @(negedge clk);
    compare_all();
    wake_i = w; out_dly_i = 11'(od); wp_dly_i = 11'(wd); gsr_en_i = ge;
    #1;
    compare_all();
    if (!w) begin
      chk(hold_o, 1'b1, "R8", "hold_o immediate");
      chk(we_o,   1'b0, "R8", "we_o immediate");
      chk(gsr_o,  1'b0, "R8", "gsr_o immediate");
      chk(done_o, 1'b0, "R8", "done_o immediate");
    end
  endtask

  task automatic sequence_run(string tag, int unsigned od, int unsigned wd, bit ge, int len);
    cur_req = tag;
    drive(1, od, wd, ge);
    run(len);
    drive(0, od, wd, ge);
    run(2);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(hold_o, 1'b1, "R1", "hold_o reset");
      chk(we_o,   1'b0, "R1", "we_o reset");
      chk(gsr_o,  1'b0, "R1", "gsr_o reset");
      chk(err_o,  1'b0, "R1", "err_o reset");
      chk(done_o, 1'b0, "R1", "done_o reset");
    end
    rst_n = 1'b1;
    run(3);

    sequence_run("R4 default", 4, 5, 0, 12);
    sequence_run("R7 gsr on", 4, 5, 1, 12);
    sequence_run("R5 long", 1, 1024, 1, 1030);
    sequence_run("R3 clamp", 0, 2047, 1, 1030);
    sequence_run("R6 equal", 7, 7, 1, 14);
    sequence_run("R6 reversed", 10, 3, 0, 16);
    sequence_run("R6 cleared", 2, 9, 1, 14);

    // R2: settings changed after capture must not move the release points
    cur_req = "R2";
    drive(1, 2, 6, 1);
    drive(1, 50, 1, 0);
    run(10);
    drive(0, 50, 1, 0);
    run(2);

    // R8: abort between the release points, then an immediate restart
    cur_req = "R8";
    drive(1, 20, 30, 1);
    run(24);
    drive(0, 20, 30, 1);
    drive(1, 3, 4, 1);
    run(10);
    drive(0, 3, 4, 1);
    run(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule